// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block sits on the programmable-logic side of a processor's external bus that moves both address and data over one shared 16-bit path. It runs on the bus clock the processor supplies. It samples every bus control line on that clock. An address phase, marked by an active-low address-valid strobe, loads the word index into a latch. The data phase that follows either writes the selected word of a small register file or drives that word back toward the processor.

Writes are steered per byte by two active-low lane enables. A read is requested with an active-low output-enable strobe. The block raises the enable of the external tri-state buffer only while that strobe and the chip select are both active, so it never fights the processor during the address phase. An active-low data acknowledge tells the processor that a strobed access has been taken. The whole register file is presented as a flat vector to user logic.

Top module: `mux_bus_slave`

## Requirements
- R1: A synchronous active-high `rst` clears every register word to 0 and the latched index to 0. After reset `dtack_n` is 1 and `ad_oe` is 0.
- R2: In a clock edge where `cs_n` and `adv_n` are both 0, the index is latched from `ad_in[3:1]`. Word k is bits [16k+15:16k] of `regs_flat`.
- R3: An address-valid pulse while `cs_n` is 1 leaves the latched index unchanged.
- R4: In a data phase (`cs_n`=0, `adv_n`=1) with only `we_lo_n`=0, bits 7:0 of the selected word take `ad_in[7:0]` and bits 15:8 are kept.
- R5: In a data phase with only `we_hi_n`=0, bits 15:8 of the selected word take `ad_in[15:8]` and bits 7:0 are kept.
- R6: With both lane enables at 0 in a data phase, the whole selected word takes `ad_in`.
- R7: While `cs_n` is 1, lane enables have no effect on the register file.
- R8: `ad_oe` is 1 exactly while `cs_n`=0 and `oe_n`=0. While `ad_oe` is 1, `ad_out` carries the word at the latched index.
- R9: `dtack_n` goes to 0 one clock after a read or write strobe is seen with `cs_n`=0. It returns to 1 in the same cycle that the strobe or the chip select is released.
- R10: Address bit 0 plays no part in word selection, so an odd address selects the same word as the even address below it.
- R11: Lane enables that are asserted during the address-valid cycle itself write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the processor |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_lo_n | input | 1 | Write enable for bits 7:0, active low |
| we_hi_n | input | 1 | Write enable for bits 15:8, active low |
| ad_in | input | 16 | Shared address/data path, input side |
| ad_out | output | 16 | Read data toward the shared path |
| ad_oe | output | 1 | Tri-state enable for the shared path |
| dtack_n | output | 1 | Data acknowledge, active low |
| regs_flat | output | 128 | All register words, concatenated, for user logic |

## Verification
On every cycle the assertions check four things. The buffer enable stays off whenever the chip select or the read strobe is inactive. Each falling edge of the acknowledge has an active strobe behind it one clock earlier. The acknowledge is inactive whenever no strobe is active. The latched index and the register file stay frozen outside a selected address or data phase. Only the bench scenarios can show which data lands where: lane steering, the ignored address bit, writes blocked in the address cycle, read-back values, and the reset contents.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   localparam int LANE_W = 8;

   // decoded view of the bus control pins for one clock
   typedef struct packed {
      logic       sel;      // chip selected
      logic       addr_ph;  // address phase this cycle
      logic       rd;       // read strobe active and selected
      logic [1:0] wr;       // per-lane write in a data phase
      logic       strobe;   // any access strobe with chip selected
   } bus_ctl_t;

endpackage

// File: rtl/mbs_decode.sv
module mbs_decode
   import mbs_pkg::*;
(
   input  logic     cs_n,
   input  logic     adv_n,
   input  logic     oe_n,
   input  logic     we_lo_n,
   input  logic     we_hi_n,
   output bus_ctl_t ctl
);

   always_comb begin
      ctl.sel     = ~cs_n;
      ctl.addr_ph = ~cs_n & ~adv_n;
      ctl.rd      = ~cs_n & ~oe_n;
      ctl.wr[0]   = ~cs_n & adv_n & ~we_lo_n;
      ctl.wr[1]   = ~cs_n & adv_n & ~we_hi_n;
      ctl.strobe  = ~cs_n & (~oe_n | ~we_lo_n | ~we_hi_n);
   end

endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [IDX_W-1:0] idx_in,
   output logic [IDX_W-1:0] idx_q
);

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (load)
         idx_q <= idx_in;
   end

endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int DATA_W    = 16,
   parameter int NREGS     = 8,
   parameter bit READ_PIPE = 1'b0,
   localparam int IDX_W    = $clog2(NREGS),
   localparam int LANES    = DATA_W / mbs_pkg::LANE_W,
   localparam int FLAT_W   = NREGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANES-1:0]  lane_we,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [FLAT_W-1:0] regs_flat
);

   localparam int LW = mbs_pkg::LANE_W;

   logic [DATA_W-1:0] words [NREGS];

   always_ff @(posedge clk) begin
      for (int r = 0; r < NREGS; r++) begin
         for (int l = 0; l < LANES; l++) begin
            if (rst)
               words[r][l*LW +: LW] <= '0;
            else if (lane_we[l] && (idx == IDX_W'(r)))
               words[r][l*LW +: LW] <= wr_data[l*LW +: LW];
         end
      end
   end

   for (genvar r = 0; r < NREGS; r++) begin : g_flat
      assign regs_flat[r*DATA_W +: DATA_W] = words[r];
   end

   if (READ_PIPE) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (rst)
            rd_q <= '0;
         else
            rd_q <= words[idx];
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = words[idx];
   end

endmodule

// File: rtl/mbs_ack.sv
module mbs_ack (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   output logic dtack_n
);

   logic seen_q;

   always_ff @(posedge clk) begin
      if (rst)
         seen_q <= 1'b0;
      else
         seen_q <= strobe;
   end

   // asserted from the clock after the strobe, dropped as soon as it goes
   assign dtack_n = ~(seen_q & strobe);

endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
   parameter int DATA_W    = 16,
   parameter int NREGS     = 8,
   parameter int ADDR_LSB  = 1,
   parameter bit READ_PIPE = 1'b0,
   localparam int IDX_W    = $clog2(NREGS),
   localparam int LANES    = DATA_W / mbs_pkg::LANE_W,
   localparam int FLAT_W   = NREGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              oe_n,
   input  logic              we_lo_n,
   input  logic              we_hi_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              dtack_n,
   output logic [FLAT_W-1:0] regs_flat
);

   import mbs_pkg::*;

   if (LANES != 2) begin : g_bad_width
      $error("mux_bus_slave: DATA_W must give exactly two byte lanes");
   end
   if ((1 << IDX_W) != NREGS || NREGS < 2) begin : g_bad_depth
      $error("mux_bus_slave: NREGS must be a power of two, at least 2");
   end
   if (ADDR_LSB + IDX_W > DATA_W) begin : g_bad_lsb
      $error("mux_bus_slave: index field does not fit the bus");
   end

   bus_ctl_t         ctl;
   logic [IDX_W-1:0] idx_q;

   mbs_decode u_decode (
      .cs_n    (cs_n),
      .adv_n   (adv_n),
      .oe_n    (oe_n),
      .we_lo_n (we_lo_n),
      .we_hi_n (we_hi_n),
      .ctl     (ctl)
   );

   mbs_addr_latch #(.IDX_W(IDX_W)) u_addr (
      .clk    (clk),
      .rst    (rst),
      .load   (ctl.addr_ph),
      .idx_in (ad_in[ADDR_LSB +: IDX_W]),
      .idx_q  (idx_q)
   );

   mbs_regfile #(
      .DATA_W    (DATA_W),
      .NREGS     (NREGS),
      .READ_PIPE (READ_PIPE)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .idx       (idx_q),
      .lane_we   (ctl.wr),
      .wr_data   (ad_in),
      .rd_data   (ad_out),
      .regs_flat (regs_flat)
   );

   mbs_ack u_ack (
      .clk     (clk),
      .rst     (rst),
      .strobe  (ctl.strobe),
      .dtack_n (dtack_n)
   );

   assign ad_oe = ctl.rd;

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
   parameter int IDX_W  = 3,
   parameter int FLAT_W = 128
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              adv_n,
   input logic              oe_n,
   input logic              we_lo_n,
   input logic              we_hi_n,
   input logic              ad_oe,
   input logic              dtack_n,
   input logic [IDX_W-1:0]  idx_q,
   input logic [FLAT_W-1:0] regs_flat
);

   p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
      (cs_n || oe_n) |-> !ad_oe);

   p_ack_cause_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(dtack_n) |-> $past(!cs_n && (!oe_n || !we_lo_n || !we_hi_n)));

   p_ack_release_r9: assert property (@(posedge clk) disable iff (rst)
      (cs_n || (oe_n && we_lo_n && we_hi_n)) |-> dtack_n);

   p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (cs_n || adv_n) |=> $stable(idx_q));

   p_regs_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (cs_n || !adv_n || (we_lo_n && we_hi_n)) |=> $stable(regs_flat));

endmodule

bind mux_bus_slave mbs_checker #(.IDX_W(IDX_W), .FLAT_W(FLAT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs_n      (cs_n),
   .adv_n     (adv_n),
   .oe_n      (oe_n),
   .we_lo_n   (we_lo_n),
   .we_hi_n   (we_hi_n),
   .ad_oe     (ad_oe),
   .dtack_n   (dtack_n),
   .idx_q     (idx_q),
   .regs_flat (regs_flat)
);

// File: tb/test_mux_bus_slave.sv
module test_mux_bus_slave;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
   logic         we_lo_n = 1'b1, we_hi_n = 1'b1;
   logic [15:0]  ad_in = '0;
   logic [15:0]  ad_out;
   logic         ad_oe, dtack_n;
   logic [127:0] regs_flat;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] mdl [8];
   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #4 clk = ~clk;

   mux_bus_slave i_mux_bus_slave (
      .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
      .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .ad_in(ad_in),
      .ad_out(ad_out), .ad_oe(ad_oe), .dtack_n(dtack_n),
      .regs_flat(regs_flat)
   );

   task automatic check(input string tag, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] mdl_flat();
      logic [127:0] f;
      for (int k = 0; k < 8; k++) f[k*16 +: 16] = mdl[k];
      return f;
   endfunction

   // monitor: pops expected read data when the acknowledge shows on a read
   always @(negedge clk) begin
      if (!rst && ad_oe && !dtack_n) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 actual %0h expected none (unexpected read)", ad_out);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {112'b0, ad_out}, {112'b0, e});
         end
      end
   end

   task automatic release_all();
      cs_n = 1; adv_n = 1; oe_n = 1; we_lo_n = 1; we_hi_n = 1;
   endtask

   task automatic addr_phase(input logic [15:0] a, input bit sel);
      @(negedge clk); #1;
      release_all();
      cs_n = !sel; adv_n = 0; ad_in = a;
   endtask

   task automatic write_word(input logic [15:0] a, input logic [15:0] d,
                             input bit lo, input bit hi);
      addr_phase(a, 1);
      @(negedge clk); #1;
      adv_n = 1; ad_in = d; we_lo_n = !lo; we_hi_n = !hi;
      #1 check("R9 ack not before a clock", {127'b0, dtack_n}, 128'd1);
      @(negedge clk); #1;
      check("R9 ack after strobe", {127'b0, dtack_n}, 128'd0);
      check("R8 no drive on write", {127'b0, ad_oe}, 128'd0);
      if (lo) mdl[a[3:1]][7:0]  = d[7:0];
      if (hi) mdl[a[3:1]][15:8] = d[15:8];
      release_all();
      #1 check("R9 ack release", {127'b0, dtack_n}, 128'd1);
   endtask

   task automatic read_noaddr(input logic [15:0] e, input string tag);
      @(negedge clk); #1;
      adv_n = 1; cs_n = 0; oe_n = 0; ad_in = '0;
      exp_q.push_back(e); tag_q.push_back(tag);
      #1 check("R8 drive on read", {127'b0, ad_oe}, 128'd1);
      @(negedge clk); #1;
      release_all();
      #1 check("R8 drive off", {127'b0, ad_oe}, 128'd0);
   endtask

   task automatic read_word(input logic [15:0] a, input string tag);
      addr_phase(a, 1);
      read_noaddr(mdl[a[3:1]], tag);
   endtask

   initial begin
      for (int k = 0; k < 8; k++) mdl[k] = '0;
      repeat (3) @(negedge clk);
      #1 rst = 0;
      @(negedge clk); #1;
      check("R1 regs zero", regs_flat, '0);
      check("R1 ad_oe low", {127'b0, ad_oe}, 128'd0);
      check("R1 dtack high", {127'b0, dtack_n}, 128'd1);
      read_noaddr(16'h0000, "R1 read index zero");

      // full word, every register
      for (int k = 0; k < 8; k++)
         write_word(16'(k * 2), 16'h1111 * 16'(k + 1) ^ 16'h5A00, 1, 1);
      check("R2 R6 register map", regs_flat, mdl_flat());
      for (int k = 7; k >= 0; k--) read_word(16'(k * 2), "R2 R6 readback");

      write_word(16'h0004, 16'hA5C3, 1, 1);
      read_word(16'h0004, "R6 full word");
      write_word(16'h0004, 16'h0011, 1, 0);
      check("R4 low lane", regs_flat, mdl_flat());
      read_word(16'h0004, "R4 low lane");
      write_word(16'h0004, 16'h2200, 0, 1);
      check("R5 high lane", regs_flat, mdl_flat());
      read_word(16'h0004, "R5 high lane");

      // odd address selects the even word
      write_word(16'h0007, 16'hBEEF, 1, 1);
      check("R10 bit0 ignored", {112'b0, regs_flat[3*16 +: 16]}, {112'b0, 16'hBEEF});
      read_word(16'h0006, "R10 bit0 ignored");

      // chip select high during data phase: no write
      addr_phase(16'h000A, 1);
      @(negedge clk); #1;
      cs_n = 1; adv_n = 1; ad_in = 16'hDEAD; we_lo_n = 0; we_hi_n = 0;
      @(negedge clk); #1;
      check("R7 no write deselected", regs_flat, mdl_flat());
      check("R9 no ack deselected", {127'b0, dtack_n}, 128'd1);
      release_all();

      // write enables during the address cycle
      @(negedge clk); #1;
      cs_n = 0; adv_n = 0; ad_in = 16'h0002; we_lo_n = 0; we_hi_n = 0;
      @(negedge clk); #1;
      release_all();
      check("R11 no write in address cycle", regs_flat, mdl_flat());

      // address pulse without chip select keeps old index
      read_word(16'h0002, "R3 before");
      addr_phase(16'h000C, 0);
      read_noaddr(mdl[1], "R3 index kept");

      // read strobe while deselected
      @(negedge clk); #1;
      cs_n = 1; oe_n = 0;
      #1 check("R8 no drive deselected", {127'b0, ad_oe}, 128'd0);
      @(negedge clk); #1;
      check("R9 no ack deselected read", {127'b0, dtack_n}, 128'd1);
      release_all();

      // reset again after data is present
      addr_phase(16'h000E, 1);
      @(negedge clk); #1;
      release_all(); rst = 1;
      @(negedge clk); #1 rst = 0;
      for (int k = 0; k < 8; k++) mdl[k] = '0;
      check("R1 regs cleared", regs_flat, '0);
      read_noaddr(16'h0000, "R1 index cleared");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R8 actual %0d expected 0 reads pending", exp_q.size());
      end
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule